// File: doc/BRIEF.md
# Boundary-Splitting Transfer Descriptor Generator

This block turns a list of buffer requests, each an address and a byte length, into a table of transfer descriptors for a scatter-gather DMA engine. No descriptor may cross a 64 KiB address boundary, so each buffer is cut into pieces. A piece runs from the current address either to the next 64 KiB boundary or to the end of the buffer, whichever comes first. Each piece becomes one 128-bit entry, written as four 32-bit words through a memory write port, with the address and length stored in big-endian byte order.

A list ends with a request that carries the last flag, or with a request of zero length. When the list ends, the block writes the length word of the final entry a second time with its end-of-list flag set. It then pulses `done` and reports the entry count. If the list needs more entries than the table holds, the block stops writing and drains the rest of the list. It then reports failure (`overflow` high, count zero), so that the requester can move the data with programmed I/O instead.

Top module: `desc_split_gen`

## Requirements
- R1: Each piece length equals the smaller of the remaining length and 0x10000 minus the low 16 bits of the current address, so no entry spans a 64 KiB boundary.
- R2: After each piece the address advances by the piece length and the remaining length drops by the same amount. A request keeps producing consecutive entries until its remaining length reaches zero.
- R3: Entry k occupies word addresses 4k to 4k+3, holding in order: zero, the byte-swapped address, zero, the byte-swapped length. Byte-swapped means bits [7:0] of the value land in bits [31:24] of the word, and so on.
- R4: When a list ends with at least one entry and no overflow, word 4(n-1)+3 is written once more with the byte-swapped value of the last piece length OR 0x80000000. The flag therefore appears as bit 7 of that stored word.
- R5: A request with the last flag set ends the list. A request of zero length also ends the list and produces no entry.
- R6: With capacity CAP entries, a list needing exactly CAP entries succeeds. A list needing more reports `overflow`=1 and count 0, and writes only the first CAP entries, with no end-of-list rewrite.
- R7: After an overflow, the remaining requests of that list are accepted and discarded without any memory write. The next list starts again at entry 0.
- R8: On success `count` equals the number of entries written. A list ended at once by a zero-length request reports count 0 and `overflow`=0.
- R9: After reset `req_ready` is 1, and `done`, `count`, `overflow` and `mem_we` are 0. `req_ready` is high only while the block waits for a request, and no memory write happens in that state.
- R10: `done` is a one-cycle pulse per list. `count` and `overflow` change only together with `done` and hold until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_addr | input | 32 | Buffer start address |
| req_len | input | LEN_W | Buffer length in bytes; zero ends the list |
| req_last | input | 1 | Final request of the list |
| mem_we | output | 1 | Descriptor memory write strobe |
| mem_waddr | output | $clog2(CAP)+2 | Word address in the descriptor table |
| mem_wdata | output | 32 | Word to write |
| done | output | 1 | One-cycle pulse when a list is finished |
| count | output | $clog2(CAP+1) | Entries written (0 on failure) |
| overflow | output | 1 | Table capacity was exceeded |

## Verification
Each accepted piece is written over four consecutive cycles. The end-of-list rewrite takes the cycle after the last piece, or the cycle after the terminating request is accepted, and `done`, `count` and `overflow` become valid one cycle after that. The bench captures every write strobe at the falling edge, where the write port is stable ahead of the rising edge that commits it. It does not count cycles: it waits for the `done` pulse, then compares the count, the flags, the number of writes and the captured table against its own splitting model. One cycle after `done`, it checks that the pulse has dropped and that the results still hold.

// File: rtl/dgen_pkg.sv
// Package: shared types and helpers for the descriptor generator.
// Assumes 32-bit descriptor words.
package dgen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EMIT   = 2'd1,
        ST_FINISH = 2'd2
    } dgen_state_e;

    localparam int          WORD_W   = 32;
    localparam logic [31:0] EOL_FLAG = 32'h8000_0000;

    // Reverse byte order of a 32-bit value (host order to big-endian table order).
    function automatic logic [31:0] swap32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction
endpackage

// File: rtl/dgen_chunker.sv
// Module: dgen_chunker
// Computes the length of the next piece: the smaller of the bytes left in the
// buffer and the distance from the current address to the next 64 KiB boundary.
// Assumes 18 <= LEN_W <= 32. The clock and reset only serve the assertions.
module dgen_chunker #(
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [15:0]      addr_lo,
    input  logic [LEN_W-1:0] remain,
    output logic [LEN_W-1:0] piece
);
    localparam logic [16:0] SPAN = 17'h10000;

    logic [16:0]      to_bnd;
    logic [LEN_W-1:0] bnd_ext;

    // Distance to boundary, then clamp to the remaining length.
    always_comb begin
        to_bnd  = SPAN - {1'b0, addr_lo};
        bnd_ext = LEN_W'(to_bnd);
        piece   = (remain < bnd_ext) ? remain : bnd_ext;
    end

    AST_PIECE_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ((LEN_W+1)'(addr_lo) + (LEN_W+1)'(piece)) <= (LEN_W+1)'(SPAN)); // R1
    AST_PIECE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (piece != '0) && (piece <= remain)); // R2
endmodule

// File: rtl/dgen_word_fmt.sv
// Module: dgen_word_fmt
// Selects the 32-bit word for the current write: one of the four words of an
// entry by phase, or the end-of-list length rewrite. Purely combinational.
// Assumes LEN_W <= 32.
module dgen_word_fmt
    import dgen_pkg::*;
#(
    parameter int LEN_W = 24
) (
    input  logic [1:0]        phase,
    input  logic              eol_sel,
    input  logic [31:0]       addr,
    input  logic [LEN_W-1:0]  piece,
    input  logic [LEN_W-1:0]  last_len,
    output logic [WORD_W-1:0] word
);
    // Word mux: zero pads, swapped address, swapped length, or flagged length.
    always_comb begin
        if (eol_sel) begin
            word = swap32(32'(last_len) | EOL_FLAG);
        end else begin
            unique case (phase)
                2'd1:    word = swap32(addr);
                2'd3:    word = swap32(32'(piece));
                default: word = '0;
            endcase
        end
    end
endmodule

// File: rtl/desc_split_gen.sv
// Module: desc_split_gen
// Accepts buffer requests, splits each at 64 KiB boundaries and writes one
// four-word entry per piece into a descriptor memory. When a list ends it sets
// the end-of-list flag on the last entry and pulses done with the entry count.
// An overflow past CAP entries discards the rest of the list and reports failure.
// Assumes CAP >= 2 and 18 <= LEN_W <= 32.
module desc_split_gen
    import dgen_pkg::*;
#(
    parameter int CAP   = 64,
    parameter int LEN_W = 24,
    localparam int IDX_W = $clog2(CAP),
    localparam int MA_W  = IDX_W + 2,
    localparam int CNT_W = $clog2(CAP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_last,
    output logic              mem_we,
    output logic [MA_W-1:0]   mem_waddr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              done,
    output logic [CNT_W-1:0]  count,
    output logic              overflow
);
    dgen_state_e      state;
    logic [1:0]       phase;
    logic [31:0]      cur_addr;
    logic [LEN_W-1:0] remain;
    logic             req_is_last;
    logic [CNT_W-1:0] ent_cnt;
    logic             ovf_flag;
    logic [LEN_W-1:0] last_len;
    logic             done_q;
    logic [CNT_W-1:0] count_q;
    logic             ovf_q;

    logic [LEN_W-1:0] piece;
    logic             emitting;
    logic             full;
    logic             eol_wr;
    logic [CNT_W-1:0] cnt_m1;

    dgen_chunker #(.LEN_W(LEN_W)) u_chunk (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (emitting),
        .addr_lo (cur_addr[15:0]),
        .remain  (remain),
        .piece   (piece)
    );

    dgen_word_fmt #(.LEN_W(LEN_W)) u_fmt (
        .phase    (phase),
        .eol_sel  (state == ST_FINISH),
        .addr     (cur_addr),
        .piece    (piece),
        .last_len (last_len),
        .word     (mem_wdata)
    );

    // Decode of write strobe and word address from the controller state.
    always_comb begin
        emitting  = (state == ST_EMIT);
        full      = (ent_cnt == CNT_W'(CAP));
        eol_wr    = (state == ST_FINISH) && !ovf_flag && (ent_cnt != '0);
        cnt_m1    = ent_cnt - CNT_W'(1);
        mem_we    = (emitting && !full) || eol_wr;
        if (state == ST_FINISH) begin
            mem_waddr = {cnt_m1[IDX_W-1:0], 2'b11};
        end else begin
            mem_waddr = {ent_cnt[IDX_W-1:0], phase};
        end
        req_ready = (state == ST_IDLE);
    end

    // Controller: accept, emit pieces word by word, close the list.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            phase       <= 2'd0;
            cur_addr    <= '0;
            remain      <= '0;
            req_is_last <= 1'b0;
            ent_cnt     <= '0;
            ovf_flag    <= 1'b0;
            last_len    <= '0;
            done_q      <= 1'b0;
            count_q     <= '0;
            ovf_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (req_len == '0) begin
                            state <= ST_FINISH;
                        end else if (ovf_flag) begin
                            if (req_last) state <= ST_FINISH;
                        end else begin
                            cur_addr    <= req_addr;
                            remain      <= req_len;
                            req_is_last <= req_last;
                            phase       <= 2'd0;
                            state       <= ST_EMIT;
                        end
                    end
                end
                ST_EMIT: begin
                    if (phase == 2'd0 && full) begin
                        ovf_flag <= 1'b1;
                        state    <= req_is_last ? ST_FINISH : ST_IDLE;
                    end else begin
                        phase <= phase + 2'd1;
                        if (phase == 2'd3) begin
                            ent_cnt  <= ent_cnt + CNT_W'(1);
                            cur_addr <= cur_addr + 32'(piece);
                            remain   <= remain - piece;
                            last_len <= piece;
                            if (remain == piece) begin
                                state <= req_is_last ? ST_FINISH : ST_IDLE;
                            end
                        end
                    end
                end
                ST_FINISH: begin
                    done_q   <= 1'b1;
                    count_q  <= ovf_flag ? '0 : ent_cnt;
                    ovf_q    <= ovf_flag;
                    ent_cnt  <= '0;
                    ovf_flag <= 1'b0;
                    phase    <= 2'd0;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done     = done_q;
    assign count    = count_q;
    assign overflow = ovf_q;

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_we); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(count) && $stable(overflow))); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done && overflow) |-> (count == '0)); // R6
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (count <= CNT_W'(CAP))); // R8
endmodule

// File: tb/desc_split_gen_test.sv
module desc_split_gen_test;
    localparam int CAP   = 4;
    localparam int LEN_W = 24;
    localparam int MA_W  = $clog2(CAP) + 2;
    localparam int CNT_W = $clog2(CAP + 1);
    localparam int NW    = 4 * CAP;
    localparam int NV    = 7;

    // Vector: {last, address, length}
    localparam logic [56:0] VEC [0:NV-1] = '{
        {1'b1, 32'h1000_0000, 24'h000100},
        {1'b1, 32'h0000_FF00, 24'h000200},
        {1'b1, 32'h0002_0000, 24'h010000},
        {1'b0, 32'h0001_FFF0, 24'h000030},
        {1'b1, 32'h5000_0000, 24'h000040},
        {1'b1, 32'h0000_8000, 24'h030000},
        {1'b1, 32'hABCD_1234, 24'h000001}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [31:0]       req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              req_last = 1'b0;
    logic              mem_we;
    logic [MA_W-1:0]   mem_waddr;
    logic [31:0]       mem_wdata;
    logic              done;
    logic [CNT_W-1:0]  count;
    logic              overflow;

    int tests = 0;
    int fails = 0;

    logic [31:0] cap_mem [0:NW-1];
    logic [31:0] exp_mem [0:NW-1];
    int          wr_count = 0;
    int          exp_cnt = 0;
    bit          exp_ovf = 0;
    logic [31:0] exp_last_len = '0;

    always #10 clk = ~clk;

    desc_split_gen #(.CAP(CAP), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_last(req_last),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .done(done), .count(count), .overflow(overflow)
    );

    // Capture writes mid-cycle, where the write port is stable.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            cap_mem[mem_waddr] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
    end

    function automatic logic [31:0] bswap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < NW; i++) begin
            exp_mem[i] = 32'hA5A5_A5A5;
            cap_mem[i] = 32'hA5A5_A5A5;
        end
        exp_cnt = 0;
        exp_ovf = 0;
        exp_last_len = '0;
        wr_count = 0;
    endtask

    // Update the model from the requirements, then hand the request over.
    task automatic send(input logic [31:0] a, input logic [23:0] l, input bit lst);
        logic [31:0] ca;
        logic [31:0] rem;
        logic [31:0] pc;
        ca  = a;
        rem = 32'(l);
        if (!exp_ovf) begin
            while (rem != 0) begin
                pc = 32'h10000 - 32'(ca[15:0]);   // R1
                if (pc > rem) pc = rem;
                if (exp_cnt == CAP) begin
                    exp_ovf = 1;
                    break;
                end
                exp_mem[4*exp_cnt + 0] = 32'h0;    // R3
                exp_mem[4*exp_cnt + 1] = bswap(ca);
                exp_mem[4*exp_cnt + 2] = 32'h0;
                exp_mem[4*exp_cnt + 3] = bswap(pc);
                exp_cnt++;
                ca  = ca + pc;                     // R2
                rem = rem - pc;
                exp_last_len = pc;
            end
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_len   = l;
        req_last  = lst;
        for (int k = 0; k < 400; k++) begin
            if (req_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_list(input string req);
        int exp_wr;
        int mism;
        int first_bad;
        bit got;
        if (!exp_ovf && exp_cnt != 0)
            exp_mem[4*(exp_cnt-1) + 3] = bswap(exp_last_len | 32'h8000_0000); // R4
        exp_wr = exp_ovf ? 4*CAP : (exp_cnt != 0 ? 4*exp_cnt + 1 : 0);
        got = 0;
        for (int k = 0; k < 400; k++) begin
            if (done) begin
                got = 1;
                break;
            end
            @(negedge clk);
        end
        check(got, req, "done pulse seen", 32'(got), 32'd1);
        check(overflow == exp_ovf, req, "overflow", 32'(overflow), 32'(exp_ovf));
        check(32'(count) == (exp_ovf ? 0 : exp_cnt), req, "count",
              32'(count), exp_ovf ? 32'd0 : 32'(exp_cnt));
        check(wr_count == exp_wr, req, "write count", 32'(wr_count), 32'(exp_wr));
        mism = 0;
        first_bad = 0;
        for (int i = 0; i < 4*exp_cnt; i++) begin
            if (cap_mem[i] !== exp_mem[i]) begin
                if (mism == 0) first_bad = i;
                mism++;
            end
        end
        check(mism == 0, req, $sformatf("table word %0d", first_bad),
              cap_mem[first_bad], exp_mem[first_bad]);
        @(negedge clk);
        check(done == 1'b0, "R10", "done drops after one cycle", 32'(done), 32'd0);
        check(32'(count) == (exp_ovf ? 0 : exp_cnt), "R10", "count held",
              32'(count), exp_ovf ? 32'd0 : 32'(exp_cnt));
        clear_model();
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        // R9: reset state
        check(req_ready == 1'b1, "R9", "ready after reset", 32'(req_ready), 32'd1);
        check(done == 1'b0 && mem_we == 1'b0, "R9", "done/we after reset",
              {30'd0, done, mem_we}, 32'd0);
        check(count == '0 && overflow == 1'b0, "R9", "count/overflow after reset",
              32'(count), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R3 R4 R8, exact capacity in vector 5 (R6)
        for (int v = 0; v < NV; v++) begin
            send(VEC[v][55:24], VEC[v][23:0], VEC[v][56]);
            if (VEC[v][56]) finish_list($sformatf("R1/R3 vec%0d", v));
        end

        // R9: ready drops while a piece is being emitted
        send(32'h0000_1000, 24'h000010, 1'b1);
        check(req_ready == 1'b0 || done == 1'b1, "R9", "ready low while busy",
              32'(req_ready), 32'd0);
        finish_list("R9 busy list");

        // R5: zero-length request terminates the list
        send(32'h3000_0000, 24'h000080, 1'b0);
        send(32'h0, 24'h0, 1'b0);
        finish_list("R5 zero-length end");

        // R8: empty list
        send(32'h0, 24'h0, 1'b1);
        finish_list("R8 empty list");

        // R6: one request needs five entries
        send(32'h0, 24'h050000, 1'b1);
        finish_list("R6 overflow");

        // R7: overflow mid-list, later requests drained without writes
        send(32'h0, 24'h040000, 1'b0);
        send(32'h0000_0100, 24'h000010, 1'b0);
        send(32'h0000_0200, 24'h000010, 1'b1);
        finish_list("R7 drain");

        // R7: next list starts clean at entry 0
        send(32'h0000_7000, 24'h000020, 1'b1);
        finish_list("R7 fresh list");

        // R10: results hold while idle
        repeat (5) @(negedge clk);
        check(count == CNT_W'(1) && overflow == 1'b0 && done == 1'b0, "R10",
              "results held while idle", 32'(count), 32'd1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule